// File: doc/BRIEF.md
# Interrupt Controller Command Port

This block is the byte-wide command and status port of one eight-line interrupt controller. Software reaches it through a single-cycle write/read strobe bus with one address bit and eight data bits. Writes either start a staged initialization sequence, change the read and masking modes, or issue end-of-service and priority-rotation commands. Reads return the mask, the pending-request vector or the in-service vector, or, once armed, a one-shot poll result.

The port keeps the mask, the rotation base (the line that currently has top priority), the vector base, the mode flags and the read selection, and presents them to the controller core. The core owns the request and in-service vectors. This block sees those vectors as inputs and sends back single-cycle clear pulses. The core also supplies the winning line for a poll, because priority resolution over requests belongs to the core. The port resolves only among in-service lines, which it needs for the non-specific end-of-service commands.

Top module: `pic_cmd_port`

## Requirements
- R1: While `rst` is high at a clock edge, every register and flag is cleared: the mask, the vector base, the rotation base, the mode flags, the read selection, the armed poll, `rdata` and all clear pulses.
- R2: A write at address 0 with data bit 4 set starts initialization. On the next edge the mask, rotation base, special mask and read selection are 0, `init_busy_o` is 1, and `lvl_clr_o` pulses for one cycle. Data bit 0 is recorded as the flag that a fourth word follows.
- R3: If the start word had bit 0 clear, nesting and auto-EOI are cleared at the start. The first following address-1 write sets `vec_base_o` to its data with bits 2:0 forced to 0. The second is consumed and ends the sequence. An address-1 write inside the sequence does not change the mask.
- R4: If the start word had bit 0 set, a third address-1 write follows the consumed one. It sets `nested_o` from data bit 4 and `auto_eoi_o` from data bit 1, and ends the sequence.
- R5: An address-0 write with bit 4 = 0 and bit 3 = 1 is a mode command. Bit 2 = 1 arms a poll. Bit 1 = 1 loads the read selection from bit 0, and bit 1 = 0 leaves it unchanged. Bit 6 = 1 loads `spec_mask_o` from bit 5, and bit 6 = 0 leaves it unchanged.
- R6: Every other address-0 write carries an operation code in bits 7:5. Codes 0 and 4 set `rot_aeoi_o` to bit 7. Code 2 changes nothing.
- R7: Code 1 clears the highest-priority set bit of `svc_bits`. Priority order starts at the rotation base and continues upward, modulo 8. The clear is a one-hot pulse on `svc_clr_o` in the cycle after the write. Code 5 does the same and also sets the rotation base to that line + 1 (mod 8). With no in-service bit set, neither code pulses or rotates.
- R8: Code 3 pulses `svc_clr_o` for the line in data bits 2:0. Code 6 sets the rotation base to (bits 2:0 + 1) mod 8. Code 7 does both for the named line.
- R9: Outside initialization, an address-1 write loads the mask with the data byte.
- R10: With no poll armed, a read returns in `rdata` on the following cycle: the mask at address 1, and at address 0 `svc_bits` if the read selection is 1 or `req_bits` if it is 0.
- R11: With a poll armed, the next read returns `poll_line` in bits 2:0 (upper bits 0) and pulses both `req_clr_o` and `svc_clr_o` for that line if `poll_hit` is 1. If `poll_hit` is 0 it returns 7 with no pulse. Either way the poll disarms, and the next read is an ordinary read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| req_bits | input | 8 | Pending-request vector from the core |
| svc_bits | input | 8 | In-service vector from the core |
| poll_hit | input | 1 | Core has a request that would win now |
| poll_line | input | 3 | Line number of that winning request |
| rdata | output | 8 | Registered read data, valid the cycle after `rd_en` |
| mask_o | output | 8 | Interrupt mask |
| vec_base_o | output | 8 | Vector base, bits 2:0 always 0 |
| rot_base_o | output | 3 | Line that currently has top priority |
| nested_o | output | 1 | Special fully nested mode |
| auto_eoi_o | output | 1 | Automatic end-of-service |
| rot_aeoi_o | output | 1 | Rotate on automatic end-of-service |
| spec_mask_o | output | 1 | Special mask mode |
| init_busy_o | output | 1 | Initialization sequence in progress |
| lvl_clr_o | output | 1 | One-cycle pulse: core clears its previous-level memory |
| svc_clr_o | output | 8 | One-cycle one-hot in-service clear request |
| req_clr_o | output | 8 | One-cycle one-hot request clear (poll) |

## Verification
The hardest situation to reach is a non-specific end-of-service when the rotation base has wrapped. The chosen line then depends on both the base and the in-service pattern across the 7-to-0 boundary. The stimulus first moves the base with a set-priority command, then presents in-service patterns whose lowest-numbered bit is not the winner, and then applies a rotating end-of-service to see the base move again. The other hard case is a poll: it takes an arming command, then a read with the core's hit inputs set, then a further read to show that the poll disarmed. The bench runs both the hit and the no-hit variant.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

    localparam int DW = 8;
    localparam int NL = 8;
    localparam int LW = $clog2(NL);
    localparam int BW = DW - LW;
    localparam logic [LW-1:0] EMPTY_LINE = LW'(NL - 1);

    typedef enum logic [1:0] {
        INIT_IDLE,
        INIT_BASE,
        INIT_SKIP,
        INIT_MODE
    } init_st_e;

    typedef enum logic [3:0] {
        WK_NONE,
        WK_START,
        WK_MODE,
        WK_ROTAE,
        WK_EOI,
        WK_EOI_ROT,
        WK_CLR,
        WK_SETB,
        WK_CLR_ROT,
        WK_NOP,
        WK_DATA
    } wr_kind_e;

    typedef struct packed {
        logic          found;
        logic [LW-1:0] line;
    } pick_t;

    function automatic logic [NL-1:0] line_bit(input logic [LW-1:0] l);
        return NL'(1) << l;
    endfunction

endpackage

// File: rtl/pic_wr_decode.sv
module pic_wr_decode
    import pic_cmd_pkg::*;
(
    input  logic     wr_en,
    input  logic     addr,
    input  logic [1:0] sel,
    input  logic [2:0] op,
    output wr_kind_e kind
);

    always_comb begin
        kind = WK_NONE;
        if (wr_en) begin
            if (addr) begin
                kind = WK_DATA;
            end else if (sel[1]) begin
                kind = WK_START;
            end else if (sel[0]) begin
                kind = WK_MODE;
            end else begin
                case (op)
                    3'd0, 3'd4: kind = WK_ROTAE;
                    3'd1:       kind = WK_EOI;
                    3'd5:       kind = WK_EOI_ROT;
                    3'd3:       kind = WK_CLR;
                    3'd6:       kind = WK_SETB;
                    3'd7:       kind = WK_CLR_ROT;
                    default:    kind = WK_NOP;
                endcase
            end
        end
    end

endmodule

// File: rtl/pic_isr_pick.sv
module pic_isr_pick
    import pic_cmd_pkg::*;
(
    input  logic [NL-1:0] svc_bits,
    input  logic [LW-1:0] base,
    output pick_t         pick
);

    logic [NL-1:0] rot;

    // rot[i] is the in-service bit of the line i steps after the base
    genvar g;
    generate
        for (g = 0; g < NL; g++) begin : g_rot
            logic [LW-1:0] idx;
            assign idx    = base + LW'(g);
            assign rot[g] = svc_bits[idx];
        end
    endgenerate

    always_comb begin
        pick = '0;
        for (int i = NL - 1; i >= 0; i--) begin
            if (rot[i]) begin
                pick.found = 1'b1;
                pick.line  = base + LW'(i);
            end
        end
    end

endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_cmd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  wr_kind_e      kind,
    input  logic          need4_in,
    input  logic [BW-1:0] base_in,
    input  logic          nest_in,
    input  logic          aeoi_in,
    output logic          busy,
    output logic [DW-1:0] vec_base,
    output logic          nested,
    output logic          auto_eoi
);

    init_st_e      st_q;
    logic          need4_q;
    logic [BW-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= INIT_IDLE;
            need4_q  <= 1'b0;
            base_q   <= '0;
            nested   <= 1'b0;
            auto_eoi <= 1'b0;
        end else if (kind == WK_START) begin
            st_q    <= INIT_BASE;
            need4_q <= need4_in;
            if (!need4_in) begin
                nested   <= 1'b0;
                auto_eoi <= 1'b0;
            end
        end else if (kind == WK_DATA) begin
            case (st_q)
                INIT_BASE: begin
                    base_q <= base_in;
                    st_q   <= INIT_SKIP;
                end
                INIT_SKIP: st_q <= need4_q ? INIT_MODE : INIT_IDLE;
                INIT_MODE: begin
                    nested   <= nest_in;
                    auto_eoi <= aeoi_in;
                    st_q     <= INIT_IDLE;
                end
                default: st_q <= INIT_IDLE;
            endcase
        end
    end

    assign busy     = (st_q != INIT_IDLE);
    assign vec_base = {base_q, {LW{1'b0}}};

    // R3: the first data word after a start fixes the vector base
    assert_base_word_R3: assert property (@(posedge clk) disable iff (rst)
        (kind == WK_DATA && st_q == INIT_BASE) |=> (vec_base[DW-1:LW] == $past(base_in)) && busy);

    // R3: without a fourth word the second data word ends the sequence
    assert_short_seq_R3: assert property (@(posedge clk) disable iff (rst)
        (kind == WK_DATA && st_q == INIT_SKIP && !need4_q) |=> !busy);

    // R4: the fourth word loads the mode flags and ends the sequence
    assert_mode_word_R4: assert property (@(posedge clk) disable iff (rst)
        (kind == WK_DATA && st_q == INIT_MODE)
        |=> (nested == $past(nest_in)) && (auto_eoi == $past(aeoi_in)) && !busy);

endmodule

// File: rtl/pic_cmd_port.sv
module pic_cmd_port
    import pic_cmd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          addr,
    input  logic [DW-1:0] wdata,
    input  logic [NL-1:0] req_bits,
    input  logic [NL-1:0] svc_bits,
    input  logic          poll_hit,
    input  logic [LW-1:0] poll_line,
    output logic [DW-1:0] rdata,
    output logic [NL-1:0] mask_o,
    output logic [DW-1:0] vec_base_o,
    output logic [LW-1:0] rot_base_o,
    output logic          nested_o,
    output logic          auto_eoi_o,
    output logic          rot_aeoi_o,
    output logic          spec_mask_o,
    output logic          init_busy_o,
    output logic          lvl_clr_o,
    output logic [NL-1:0] svc_clr_o,
    output logic [NL-1:0] req_clr_o
);

    wr_kind_e      kind;
    pick_t         pick;
    logic          rdsel_q;
    logic          poll_q;
    logic          poll_take;
    logic [LW-1:0] named_line;
    logic [NL-1:0] svc_clr_d;
    logic [NL-1:0] req_clr_d;
    logic [LW-1:0] rot_base_d;

    pic_wr_decode u_dec (
        .wr_en (wr_en),
        .addr  (addr),
        .sel   (wdata[4:3]),
        .op    (wdata[7:5]),
        .kind  (kind)
    );

    pic_init_seq u_init (
        .clk      (clk),
        .rst      (rst),
        .kind     (kind),
        .need4_in (wdata[0]),
        .base_in  (wdata[DW-1:LW]),
        .nest_in  (wdata[4]),
        .aeoi_in  (wdata[1]),
        .busy     (init_busy_o),
        .vec_base (vec_base_o),
        .nested   (nested_o),
        .auto_eoi (auto_eoi_o)
    );

    pic_isr_pick u_pick (
        .svc_bits (svc_bits),
        .base     (rot_base_o),
        .pick     (pick)
    );

    assign named_line = wdata[LW-1:0];
    assign poll_take  = rd_en && poll_q;

    // clear pulses and next rotation base
    always_comb begin
        svc_clr_d  = '0;
        req_clr_d  = '0;
        rot_base_d = rot_base_o;
        if (poll_take && poll_hit) begin
            svc_clr_d = line_bit(poll_line);
            req_clr_d = line_bit(poll_line);
        end
        case (kind)
            WK_START: rot_base_d = '0;
            WK_EOI: begin
                if (pick.found) svc_clr_d = svc_clr_d | line_bit(pick.line);
            end
            WK_EOI_ROT: begin
                if (pick.found) begin
                    svc_clr_d  = svc_clr_d | line_bit(pick.line);
                    rot_base_d = pick.line + LW'(1);
                end
            end
            WK_CLR: svc_clr_d = svc_clr_d | line_bit(named_line);
            WK_SETB: rot_base_d = named_line + LW'(1);
            WK_CLR_ROT: begin
                svc_clr_d  = svc_clr_d | line_bit(named_line);
                rot_base_d = named_line + LW'(1);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_o      <= '0;
            rot_base_o  <= '0;
            rot_aeoi_o  <= 1'b0;
            spec_mask_o <= 1'b0;
            rdsel_q     <= 1'b0;
            poll_q      <= 1'b0;
            rdata       <= '0;
            lvl_clr_o   <= 1'b0;
            svc_clr_o   <= '0;
            req_clr_o   <= '0;
        end else begin
            svc_clr_o  <= svc_clr_d;
            req_clr_o  <= req_clr_d;
            rot_base_o <= rot_base_d;
            lvl_clr_o  <= (kind == WK_START);
            if (rd_en) begin
                if (poll_q) begin
                    poll_q <= 1'b0;
                    rdata  <= poll_hit ? DW'(poll_line) : DW'(EMPTY_LINE);
                end else if (addr) begin
                    rdata <= mask_o;
                end else begin
                    rdata <= rdsel_q ? svc_bits : req_bits;
                end
            end
            case (kind)
                WK_START: begin
                    mask_o      <= '0;
                    spec_mask_o <= 1'b0;
                    rdsel_q     <= 1'b0;
                end
                WK_MODE: begin
                    if (wdata[2]) poll_q      <= 1'b1;
                    if (wdata[1]) rdsel_q     <= wdata[0];
                    if (wdata[6]) spec_mask_o <= wdata[5];
                end
                WK_ROTAE: rot_aeoi_o <= wdata[7];
                WK_DATA: begin
                    if (!init_busy_o) mask_o <= wdata;
                end
                default: ;
            endcase
        end
    end

    // R2: a start word clears the mask and rotation base and enters the sequence
    assert_start_clears_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !addr && wdata[4]) |=> (mask_o == '0) && (rot_base_o == '0) && init_busy_o && lvl_clr_o);

    // R7: in-service clears are never more than one line at a time
    assert_clr_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(svc_clr_o));

    // R8: set-priority moves the base one past the named line
    assert_set_base_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !addr && wdata[7:3] == 5'b11000) |=> (rot_base_o == $past(wdata[LW-1:0]) + LW'(1)));

    // R9: a data word outside the sequence becomes the mask
    assert_mask_load_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr && !init_busy_o) |=> (mask_o == $past(wdata)));

    // R10: an ordinary address-1 read returns the mask one cycle later
    assert_rd_mask_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr && !poll_q && !wr_en) |=> (rdata == $past(mask_o)));

    // R11: a poll serves exactly one read
    assert_poll_once_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_en && poll_q && !wr_en) |=> !poll_q);

    // R11: a poll clears request and in-service together
    assert_poll_pair_R11: assert property (@(posedge clk) disable iff (rst)
        (req_clr_o != '0) |-> ((svc_clr_o & req_clr_o) == req_clr_o));

endmodule

// File: tb/pic_cmd_port_bench.sv
module pic_cmd_port_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
    logic [7:0] wdata = '0, req_bits = '0, svc_bits = '0;
    logic       poll_hit = 1'b0;
    logic [2:0] poll_line = '0;
    logic [7:0] rdata, mask_o, vec_base_o, svc_clr_o, req_clr_o;
    logic [2:0] rot_base_o;
    logic       nested_o, auto_eoi_o, rot_aeoi_o, spec_mask_o, init_busy_o, lvl_clr_o;

    always #5 clk = ~clk;

    pic_cmd_port u_pic_cmd_port (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .req_bits(req_bits), .svc_bits(svc_bits),
        .poll_hit(poll_hit), .poll_line(poll_line), .rdata(rdata),
        .mask_o(mask_o), .vec_base_o(vec_base_o), .rot_base_o(rot_base_o),
        .nested_o(nested_o), .auto_eoi_o(auto_eoi_o), .rot_aeoi_o(rot_aeoi_o),
        .spec_mask_o(spec_mask_o), .init_busy_o(init_busy_o), .lvl_clr_o(lvl_clr_o),
        .svc_clr_o(svc_clr_o), .req_clr_o(req_clr_o)
    );

    // reference model state
    int m_mask, m_vbase, m_base, m_nest, m_aeoi, m_rae, m_smask, m_rdsel, m_poll;
    int m_step, m_need4, m_rdata, m_lvl, m_svc_clr, m_req_clr;
    int checks = 0, fails = 0;
    string tag = "R1";
    bit done = 0;

    task automatic model();
        int op, line, found, idx;
        m_lvl = 0; m_svc_clr = 0; m_req_clr = 0;
        if (rst) begin
            m_mask = 0; m_vbase = 0; m_base = 0; m_nest = 0; m_aeoi = 0; m_rae = 0;
            m_smask = 0; m_rdsel = 0; m_poll = 0; m_step = 0; m_need4 = 0; m_rdata = 0;
            return;
        end
        if (rd_en) begin
            if (m_poll != 0) begin
                m_poll = 0;
                if (poll_hit) begin
                    m_rdata = poll_line;
                    m_svc_clr = 1 << poll_line;
                    m_req_clr = 1 << poll_line;
                end else m_rdata = 7;
            end else if (addr) m_rdata = m_mask;
            else m_rdata = (m_rdsel != 0) ? svc_bits : req_bits;
        end
        if (!wr_en) return;
        if (addr) begin
            case (m_step)
                0: m_mask = wdata;
                1: begin m_vbase = wdata & 8'hF8; m_step = 2; end
                2: m_step = (m_need4 != 0) ? 3 : 0;
                default: begin m_nest = wdata[4]; m_aeoi = wdata[1]; m_step = 0; end
            endcase
        end else if (wdata[4]) begin
            m_need4 = wdata[0]; m_mask = 0; m_base = 0; m_smask = 0; m_rdsel = 0;
            m_lvl = 1; m_step = 1;
            if (!wdata[0]) begin m_nest = 0; m_aeoi = 0; end
        end else if (wdata[3]) begin
            if (wdata[2]) m_poll = 1;
            if (wdata[1]) m_rdsel = wdata[0];
            if (wdata[6]) m_smask = wdata[5];
        end else begin
            op = wdata[7:5];
            line = wdata[2:0];
            if (op == 0 || op == 4) m_rae = wdata[7];
            if (op == 1 || op == 5) begin
                found = -1;
                for (int i = 0; i < 8; i++) begin
                    idx = (m_base + i) % 8;
                    if (found < 0 && svc_bits[idx]) found = idx;
                end
                if (found >= 0) begin
                    m_svc_clr = m_svc_clr | (1 << found);
                    if (op == 5) m_base = (found + 1) % 8;
                end
            end
            if (op == 3 || op == 7) m_svc_clr = m_svc_clr | (1 << line);
            if (op == 6 || op == 7) m_base = (line + 1) % 8;
        end
    endtask

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("rdata R10 R11", rdata, m_rdata);
        chk("mask R9", mask_o, m_mask);
        chk("vec_base R3", vec_base_o, m_vbase);
        chk("rot_base R8", rot_base_o, m_base);
        chk("nested R4", nested_o, m_nest);
        chk("auto_eoi R4", auto_eoi_o, m_aeoi);
        chk("rot_aeoi R6", rot_aeoi_o, m_rae);
        chk("spec_mask R5", spec_mask_o, m_smask);
        chk("init_busy R2", init_busy_o, (m_step != 0) ? 1 : 0);
        chk("lvl_clr R2", lvl_clr_o, m_lvl);
        chk("svc_clr R7", svc_clr_o, m_svc_clr);
        chk("req_clr R11", req_clr_o, m_req_clr);
    endtask

    task automatic step(input bit w, input bit r, input bit a, input logic [7:0] d);
        wr_en = w; rd_en = r; addr = a; wdata = d;
        @(posedge clk);
        model();
        @(negedge clk);
        compare();
        wr_en = 0; rd_en = 0;
    endtask

    task automatic wr(input bit a, input logic [7:0] d); step(1, 0, a, d); endtask
    task automatic rd(input bit a); step(0, 1, a, 8'h00); endtask
    task automatic idle(); step(0, 0, 0, 8'h00); endtask

    initial begin
        @(negedge clk);
        tag = "R1";
        wdata = 8'hFF; req_bits = 8'hFF; svc_bits = 8'hFF;
        for (int i = 0; i < 3; i++) step(1, 1, 1, 8'hFF);
        rst = 0;
        idle();

        tag = "R9 R10";
        wr(1, 8'hA5); rd(1);
        req_bits = 8'h3C; svc_bits = 8'h81; rd(0);

        tag = "R5";
        wr(0, 8'h0B); rd(0);
        wr(0, 8'h09); rd(0);
        wr(0, 8'h0A); rd(0);
        wr(0, 8'h68); wr(0, 8'h28); wr(0, 8'h48);

        tag = "R4";
        wr(0, 8'h11); wr(1, 8'h48); wr(1, 8'h00); rd(1); wr(1, 8'h12); idle();
        tag = "R9";
        wr(1, 8'hF0); rd(1);
        tag = "R3";
        wr(0, 8'h6B); wr(0, 8'hC3);
        wr(0, 8'h10); wr(1, 8'h27); rd(1); wr(1, 8'h55); rd(1);
        wr(1, 8'h0F); rd(1);

        tag = "R6";
        wr(0, 8'h80); wr(0, 8'h40); wr(0, 8'h00); wr(0, 8'h9F); wr(0, 8'h47);

        tag = "R7";
        svc_bits = 8'h50; wr(0, 8'h20);
        tag = "R8";
        wr(0, 8'hC5);
        tag = "R7";
        wr(0, 8'h20);
        svc_bits = 8'h12; wr(0, 8'hA0);
        svc_bits = 8'h00; wr(0, 8'h20); wr(0, 8'hA0);
        svc_bits = 8'h81; wr(0, 8'hC6); wr(0, 8'hA0);

        tag = "R8";
        wr(0, 8'h63); wr(0, 8'hE7); wr(0, 8'hC7); wr(0, 8'hE2);

        tag = "R11";
        poll_hit = 1; poll_line = 3'd5;
        wr(0, 8'h0C); rd(0); rd(1);
        poll_hit = 0; wr(0, 8'h0C); rd(1); rd(1);
        poll_hit = 1; poll_line = 3'd0; wr(0, 8'h0E); idle(); rd(0); rd(0);

        tag = "R1";
        rst = 1; idle(); rst = 0; idle();

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule